// File: doc/BRIEF.md
# Instrument Status Byte Service Request Unit

This unit builds the eight-bit status byte of a programmable measurement instrument and raises a service request line toward the host controller. Two sticky event registers collect one-cycle event pulses: a standard group and an extended group. Each has an enable mask that the host can write. The masked summaries of these registers, the not-empty states of the response queue and the error queue, and a host-written request enable register together decide whether the instrument asks for service.

The host reads the byte in two ways. A serial poll returns the edge-latched request bit in bit 6 and clears it on the poll strobe. A query returns the live master summary in bit 6 and leaves the request bit alone. Bus transport, command parsing and queue storage sit outside this block. All pins are plain control and status signals. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `stb_srq_unit`

## Requirements
- R1: After reset, both event registers, both event masks, the request enable register and the request bit are all 0, and the request line is low.
- R2: Bits 7, 1 and 0 of the poll byte and of the query byte always read 0.
- R3: Bit 2 of both bytes is 1 exactly when the error queue is not empty (`errq_empty` low). Bit 4 is 1 exactly when the response queue is not empty (`outq_empty` low).
- R4: Each event register bit is set one cycle after a pulse on its input bit and then holds. A read strobe clears the whole register in the next cycle. A pulse in the same cycle as the read strobe survives the clear.
- R5: Bit 5 of both bytes is 1 when the standard event register ANDed with its mask is nonzero. Bit 3 is 1 when the extended event register ANDed with its mask is nonzero.
- R6: Each event mask takes its write data one cycle after its write strobe, and it reads back on its own output.
- R7: `mss` is 1 when bits 7..0 of the status byte, with bit 6 forced to 0, ANDed with the request enable register are nonzero. Bit 6 of the query byte equals `mss`.
- R8: Bit 6 of the request enable register ignores writes and reads back 0. Clearing an enable bit stops that status bit from raising `mss`, but the status bit still reads normally in both bytes.
- R9: The request bit is set in the cycle after `mss` goes from 0 to 1. `srq` and bit 6 of the poll byte both equal the request bit.
- R10: A poll strobe clears the request bit in the next cycle. A rise of `mss` in the same cycle as the strobe wins, and the request bit is set. The query byte has no effect on the request bit.
- R11: The request bit is 0 in the cycle after any cycle in which `mss` is 0. It is not set again while `mss` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_evt_pulse | input | SEV_W | One-cycle standard event pulses |
| std_evt_rd | input | 1 | Read strobe; clears the standard event register |
| std_evt_q | output | SEV_W | Standard event register contents |
| std_en_we | input | 1 | Standard mask write strobe |
| std_en_wdata | input | SEV_W | Standard mask write data |
| std_en_q | output | SEV_W | Standard mask readback |
| ext_evt_pulse | input | XEV_W | One-cycle extended event pulses |
| ext_evt_rd | input | 1 | Read strobe; clears the extended event register |
| ext_evt_q | output | XEV_W | Extended event register contents |
| ext_en_we | input | 1 | Extended mask write strobe |
| ext_en_wdata | input | XEV_W | Extended mask write data |
| ext_en_q | output | XEV_W | Extended mask readback |
| outq_empty | input | 1 | Response queue is empty |
| errq_empty | input | 1 | Error queue is empty |
| sre_we | input | 1 | Request enable write strobe |
| sre_wdata | input | 8 | Request enable write data |
| sre_q | output | 8 | Request enable readback (bit 6 reads 0) |
| poll | input | 1 | Serial-poll strobe |
| poll_byte | output | 8 | Status byte with the request bit in bit 6 |
| query_byte | output | 8 | Status byte with `mss` in bit 6 |
| mss | output | 1 | Master summary |
| srq | output | 1 | Service request line |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a poll strobe and the first cycle of a rise in `mss`. The bench sets an event pulse, waits one edge for the summary to rise, and then asserts the poll strobe in that same cycle. The request line is expected high afterwards, because the set wins. The second pair is an event pulse and a read strobe on the same register. The bench checks that only the newly pulsed bit remains in the register, and that the summary bits follow that remaining value.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned EAV_B  = 2;
  localparam int unsigned EES_B  = 3;
  localparam int unsigned MAV_B  = 4;
  localparam int unsigned ESB_B  = 5;
  localparam int unsigned RQS_B  = 6;
  localparam logic [BYTE_W-1:0] SRE_KEEP = ~(8'(1) << RQS_B);

  function automatic logic [BYTE_W-1:0] base_byte(input logic eav, input logic ees,
                                                  input logic mav, input logic esb);
    logic [BYTE_W-1:0] b;
    b        = '0;
    b[EAV_B] = eav;
    b[EES_B] = ees;
    b[MAV_B] = mav;
    b[ESB_B] = esb;
    return b;
  endfunction
endpackage

// File: rtl/stb_evt_latch.sv
module stb_evt_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] q_o,
  output logic         sum_o
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else        held <= (rd_i ? '0 : held) | set_i;
  end

  assign q_o   = held;
  assign sum_o = |(held & en_i);
endmodule

// File: rtl/stb_mask_reg.sv
module stb_mask_reg #(
  parameter int unsigned       W    = 8,
  parameter logic [W-1:0]      KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= wdata_i & KEEP;
  end
endmodule

// File: rtl/stb_srq_ctrl.sv
module stb_srq_ctrl
  import stb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eav_i,
  input  logic              ees_i,
  input  logic              mav_i,
  input  logic              esb_i,
  input  logic [BYTE_W-1:0] sre_i,
  input  logic              poll_i,
  output logic [BYTE_W-1:0] poll_byte_o,
  output logic [BYTE_W-1:0] query_byte_o,
  output logic              mss_o,
  output logic              rqs_o
);
  logic [BYTE_W-1:0] base;
  logic              mss_d;
  logic              rqs;
  logic              rise;

  assign base  = base_byte(eav_i, ees_i, mav_i, esb_i);
  assign mss_o = |(base & sre_i & SRE_KEEP);
  assign rise  = mss_o & ~mss_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mss_d <= 1'b0;
      rqs   <= 1'b0;
    end else begin
      mss_d <= mss_o;
      if (rise)                 rqs <= 1'b1;
      else if (poll_i || !mss_o) rqs <= 1'b0;
    end
  end

  always_comb begin
    poll_byte_o          = base;
    poll_byte_o[RQS_B]   = rqs;
    query_byte_o         = base;
    query_byte_o[RQS_B]  = mss_o;
  end

  assign rqs_o = rqs;
endmodule

// File: rtl/stb_srq_unit.sv
module stb_srq_unit
  import stb_pkg::*;
#(
  parameter int unsigned SEV_W = 8,
  parameter int unsigned XEV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEV_W-1:0]  std_evt_pulse,
  input  logic              std_evt_rd,
  output logic [SEV_W-1:0]  std_evt_q,
  input  logic              std_en_we,
  input  logic [SEV_W-1:0]  std_en_wdata,
  output logic [SEV_W-1:0]  std_en_q,
  input  logic [XEV_W-1:0]  ext_evt_pulse,
  input  logic              ext_evt_rd,
  output logic [XEV_W-1:0]  ext_evt_q,
  input  logic              ext_en_we,
  input  logic [XEV_W-1:0]  ext_en_wdata,
  output logic [XEV_W-1:0]  ext_en_q,
  input  logic              outq_empty,
  input  logic              errq_empty,
  input  logic              sre_we,
  input  logic [BYTE_W-1:0] sre_wdata,
  output logic [BYTE_W-1:0] sre_q,
  input  logic              poll,
  output logic [BYTE_W-1:0] poll_byte,
  output logic [BYTE_W-1:0] query_byte,
  output logic              mss,
  output logic              srq
);
  logic esb_sum, ees_sum;

  stb_mask_reg #(.W(SEV_W), .KEEP({SEV_W{1'b1}})) u_std_en (
    .clk(clk), .rst_n(rst_n), .we_i(std_en_we), .wdata_i(std_en_wdata), .q_o(std_en_q));

  stb_mask_reg #(.W(XEV_W), .KEEP({XEV_W{1'b1}})) u_ext_en (
    .clk(clk), .rst_n(rst_n), .we_i(ext_en_we), .wdata_i(ext_en_wdata), .q_o(ext_en_q));

  stb_mask_reg #(.W(BYTE_W), .KEEP(SRE_KEEP)) u_sre (
    .clk(clk), .rst_n(rst_n), .we_i(sre_we), .wdata_i(sre_wdata), .q_o(sre_q));

  stb_evt_latch #(.W(SEV_W)) u_std_evt (
    .clk(clk), .rst_n(rst_n), .set_i(std_evt_pulse), .rd_i(std_evt_rd),
    .en_i(std_en_q), .q_o(std_evt_q), .sum_o(esb_sum));

  stb_evt_latch #(.W(XEV_W)) u_ext_evt (
    .clk(clk), .rst_n(rst_n), .set_i(ext_evt_pulse), .rd_i(ext_evt_rd),
    .en_i(ext_en_q), .q_o(ext_evt_q), .sum_o(ees_sum));

  stb_srq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .eav_i(~errq_empty), .ees_i(ees_sum), .mav_i(~outq_empty), .esb_i(esb_sum),
    .sre_i(sre_q), .poll_i(poll),
    .poll_byte_o(poll_byte), .query_byte_o(query_byte), .mss_o(mss), .rqs_o(srq));
endmodule

// File: rtl/stb_srq_chk.sv
module stb_srq_chk #(
  parameter int unsigned SEV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             poll,
  input logic             mss,
  input logic             srq,
  input logic             std_evt_rd,
  input logic [SEV_W-1:0] std_evt_q,
  input logic [7:0]       sre_q,
  input logic [7:0]       poll_byte,
  input logic [7:0]       query_byte
);
  assert_unused_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_byte[7] == 1'b0) && (poll_byte[1:0] == 2'b00) &&
    (query_byte[7] == 1'b0) && (query_byte[1:0] == 2'b00));

  assert_evt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !std_evt_rd |=> ((std_evt_q & $past(std_evt_q)) == $past(std_evt_q)));

  assert_query_mss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    query_byte[6] == mss);

  assert_sre_bit6_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sre_q[6] == 1'b0);

  assert_rqs_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mss) |=> srq);

  assert_poll_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && srq) |=> !srq);

  assert_mss_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mss |=> !srq);

  assert_no_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mss && $past(mss) && !srq) |=> !srq);
endmodule

bind stb_srq_unit stb_srq_chk #(.SEV_W(SEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll(poll), .mss(mss), .srq(srq),
  .std_evt_rd(std_evt_rd), .std_evt_q(std_evt_q), .sre_q(sre_q),
  .poll_byte(poll_byte), .query_byte(query_byte));

// File: tb/tb_stb_srq_unit.sv
module tb_stb_srq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SEV_W = 8;
  localparam int XEV_W = 16;

  // {errq_empty, outq_empty, sre[7:0], expected query byte[7:0]}
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'hFF, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h04},
    {1'b0, 1'b1, 8'h04, 8'h44},
    {1'b1, 1'b0, 8'h04, 8'h10},
    {1'b1, 1'b0, 8'h10, 8'h50},
    {1'b0, 1'b0, 8'h40, 8'h14}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SEV_W-1:0] std_evt_pulse = '0, std_evt_q, std_en_wdata = '0, std_en_q;
  logic [XEV_W-1:0] ext_evt_pulse = '0, ext_evt_q, ext_en_wdata = '0, ext_en_q;
  logic std_evt_rd = 1'b0, std_en_we = 1'b0, ext_evt_rd = 1'b0, ext_en_we = 1'b0;
  logic outq_empty = 1'b1, errq_empty = 1'b1, sre_we = 1'b0, poll = 1'b0;
  logic [7:0] sre_wdata = '0, sre_q, poll_byte, query_byte;
  logic mss, srq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stb_srq_unit #(.SEV_W(SEV_W), .XEV_W(XEV_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_sre(input logic [7:0] v);
    sre_wdata = v; sre_we = 1'b1; step(); sre_we = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 poll_byte", poll_byte, 8'h00);
    chk("R1 query_byte", query_byte, 8'h00);
    chk("R1 srq", srq, 0);
    chk("R1 sre_q", sre_q, 0);
    chk("R1 masks", {std_en_q, ext_en_q}, 0);
    chk("R1 events", {std_evt_q, ext_evt_q}, 0);

    // Table walk: R3 queue bits, R7 summary, R8 masking and bit 6 ignored
    for (int i = 0; i < NVEC; i++) begin
      step();
      errq_empty = VEC[i][17];
      outq_empty = VEC[i][16];
      wr_sre(VEC[i][15:8]);
      #1;
      chk($sformatf("R3/R7/R8 vec%0d query", i), query_byte, VEC[i][7:0]);
      chk($sformatf("R7 vec%0d mss", i), mss, VEC[i][6]);
    end

    // R2 unused bits with everything active
    wr_sre(8'hFF);
    #1;
    chk("R8 sre bit6 readback", sre_q, 8'hBF);
    chk("R2 poll unused", {poll_byte[7], poll_byte[1:0]}, 0);
    chk("R2 query unused", {query_byte[7], query_byte[1:0]}, 0);

    // Quiet state
    step();
    errq_empty = 1'b1; outq_empty = 1'b1;
    wr_sre(8'h00);

    // R6 masks
    std_en_wdata = 8'h0A; std_en_we = 1'b1;
    ext_en_wdata = 16'h8001; ext_en_we = 1'b1;
    #1;
    chk("R6 std mask before edge", std_en_q, 0);
    step(); std_en_we = 1'b0; ext_en_we = 1'b0;
    chk("R6 std mask", std_en_q, 8'h0A);
    chk("R6 ext mask", ext_en_q, 16'h8001);

    // R4/R5 standard register
    std_evt_pulse = 8'h04; step(); std_evt_pulse = '0;
    chk("R4 std set", std_evt_q, 8'h04);
    chk("R5 esb masked", query_byte[5], 0);
    step();
    chk("R4 std holds", std_evt_q, 8'h04);
    std_evt_pulse = 8'h08; step(); std_evt_pulse = '0;
    chk("R4 std accum", std_evt_q, 8'h0C);
    chk("R5 esb set", poll_byte[5], 1);
    std_evt_rd = 1'b1; std_evt_pulse = 8'h10; step();
    std_evt_rd = 1'b0; std_evt_pulse = '0;
    chk("R4 set beats read", std_evt_q, 8'h10);
    chk("R5 esb after clear", query_byte[5], 0);
    std_evt_rd = 1'b1; step(); std_evt_rd = 1'b0;
    chk("R4 read clears", std_evt_q, 8'h00);

    // R5 extended register
    ext_evt_pulse = 16'h0002; step(); ext_evt_pulse = '0;
    chk("R5 ees masked", query_byte[3], 0);
    ext_evt_pulse = 16'h8000; step(); ext_evt_pulse = '0;
    chk("R5 ees set", query_byte[3], 1);
    chk("R8 ees reads while unenabled", mss, 0);
    ext_evt_rd = 1'b1; step(); ext_evt_rd = 1'b0;
    chk("R4 ext read clears", ext_evt_q, 0);

    // R9 request on rise of mss
    wr_sre(8'h20);
    std_evt_pulse = 8'h02; step(); std_evt_pulse = '0;
    chk("R9 mss up", mss, 1);
    chk("R9 srq not yet", srq, 0);
    step();
    chk("R9 srq set", srq, 1);
    chk("R9 poll bit6", poll_byte[6], 1);
    step();
    chk("R10 query leaves rqs", srq, 1);

    // R10 poll clears; R11 no re-set while mss stays high
    poll = 1'b1; step(); poll = 1'b0;
    chk("R10 poll clears srq", srq, 0);
    chk("R10 poll bit6", poll_byte[6], 0);
    chk("R7 query bit6 still mss", query_byte[6], 1);
    repeat (3) step();
    chk("R11 no re-set", srq, 0);

    // R11 mss fall clears request
    std_evt_rd = 1'b1; step(); std_evt_rd = 1'b0;
    chk("R11 mss low", mss, 0);
    std_evt_pulse = 8'h02; step(); std_evt_pulse = '0;
    step();
    chk("R9 srq set again", srq, 1);
    std_evt_rd = 1'b1; step(); std_evt_rd = 1'b0;
    step();
    chk("R11 srq cleared by mss fall", srq, 0);

    // R10 poll coinciding with mss rise: set wins
    std_evt_pulse = 8'h02; step(); std_evt_pulse = '0;
    poll = 1'b1; step(); poll = 1'b0;
    chk("R10 rise beats poll", srq, 1);

    done = 1'b1;
    summary();
  end
endmodule